// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block is the digital fault manager of a two-phase buck regulator controller. It takes comparator flags that have already been digitized and passes each through a two-flop synchronizer. Its inputs cover overcurrent at half, full and double the set level, phase imbalance, undervoltage, two overvoltage levels, a crowbar release level, over-temperature, phase mode, enable and supply-good. From these it decides whether the power stage may switch. Delayed faults are timed in ticks of a divided clock. A fault only latches when its condition holds without a break for the whole window.

A state machine holds the operating state. The states are ST_IDLE (off), ST_START (one cycle that requests soft-start), ST_RUN (regulating), ST_FAULT (latched off), ST_CROWBAR (low-side switches on) and ST_OVLOCK (crowbar done, all off). Supply loss sends every state to ST_IDLE. The other transitions are:
- ST_IDLE to ST_START when enable and supply are good; ST_IDLE to ST_CROWBAR on a high overvoltage.
- ST_START to ST_RUN after one cycle.
- ST_START or ST_RUN to ST_FAULT on a hard overcurrent or an expired delay timer; to ST_IDLE when enable drops; to ST_CROWBAR on a high overvoltage.
- ST_FAULT to ST_IDLE when enable drops; to ST_CROWBAR on a high overvoltage.
- ST_CROWBAR to ST_OVLOCK when the output falls under the release level.
- ST_OVLOCK back to ST_CROWBAR on a new high overvoltage.

Top module: `vr_fault_supervisor`

## Requirements
- R1: After reset, and while enable is low, power-good is 0, every high-side and low-side enable is 0 and throttle_n_o is 1.
- R2: When enable and supply-good are both high and no high overvoltage is present, ss_req_o pulses high for exactly one cycle. After that pulse, power-good is 1 and every gate enable is 1.
- R3: A hard overcurrent turns off every gate enable and drops power-good no later than 3 clock edges after the input changes, with no timer. In two-phase mode (two_phase_i=1) the hard flag is oc_short_i. In single-phase mode it is oc_set_i.
- R4: The delayed overcurrent flag latches a fault once it has held for OC_TICKS ticks, and not when it holds for fewer than OC_TICKS-1 ticks. Any break restarts the count. The flag is oc_set_i in two-phase mode and oc_half_i in single-phase mode; the other flag has no effect.
- R5: Phase imbalance latches a fault after LONG_TICKS ticks in two-phase mode only. In single-phase mode it has no effect.
- R6: Undervoltage and low-level overvoltage each latch a fault after LONG_TICKS ticks.
- R7: A latched fault turns off all gates and drops power-good. It stays latched after the cause goes away. It clears when enable goes low or supply-good drops, and a return of both to high issues a new soft-start pulse.
- R8: A high overvoltage drives power-good to 0, the high-side enables to 0 and the low-side enables to 1. This holds until ov_low_i shows the output is under the release level, and then all gates turn off.
- R9: High-overvoltage detection works in every state while supply-good is high. This includes ST_FAULT, enable low and after a finished crowbar, and each new crossing restarts the crowbar.
- R10: The high-overvoltage latch ignores the enable input and clears only when supply-good drops.
- R11: throttle_n_o is the inverse of the synchronized hot_i. Temperature has no effect on the gates or on power-good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_half_i | input | 1 | Current above half the set level |
| oc_set_i | input | 1 | Current above the set level |
| oc_short_i | input | 1 | Current above twice the set level |
| imbal_i | input | 1 | Phase current difference above limit |
| uv_i | input | 1 | Output below target by the undervoltage margin |
| ov_lo_i | input | 1 | Output above target by the low overvoltage margin |
| ov_hi_i | input | 1 | Output above the absolute high overvoltage level |
| ov_low_i | input | 1 | Output below the crowbar release level |
| hot_i | input | 1 | Temperature sense below its threshold voltage |
| two_phase_i | input | 1 | 1 = two-phase mode, 0 = single-phase mode |
| en_i | input | 1 | Regulator enable |
| supply_ok_i | input | 1 | Controller supply above its minimum |
| pgood_o | output | 1 | Power-good |
| hs_en_o | output | NPHASE | High-side gate enable per phase |
| ls_en_o | output | NPHASE | Low-side gate enable per phase |
| ss_req_o | output | 1 | One-cycle soft-start request |
| throttle_n_o | output | 1 | Active-low thermal throttle |

## Verification
The bench sits on both sides of each delay window. Overcurrent that is held for three ticks, or broken and then resumed, must not trip. A design that does not clear its timer on a break would trip on the resumed pulse. The bench checks that single-phase mode swaps both overcurrent flags and masks imbalance. A design with a fixed threshold would miss the half-level fault or trip on the full level. The high-overvoltage path is driven with enable low, after an undervoltage fault and after a finished crowbar. Logic that clears the crowbar with enable, or that ignores the detector outside run, would show all-off gates where the low-side switches should be on.

// File: rtl/vr_fault_pkg.sv
package vr_fault_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RUN,
        ST_FAULT,
        ST_CROWBAR,
        ST_OVLOCK
    } sup_state_t;

    // delay timer slots
    localparam int DLY_OC  = 0;
    localparam int DLY_IMB = 1;
    localparam int DLY_UV  = 2;
    localparam int DLY_OVL = 3;
    localparam int NUM_DLY = 4;

    // synchronizer bit slots
    localparam int SI_OC_HALF  = 0;
    localparam int SI_OC_SET   = 1;
    localparam int SI_OC_SHORT = 2;
    localparam int SI_IMBAL    = 3;
    localparam int SI_UV       = 4;
    localparam int SI_OV_LO    = 5;
    localparam int SI_OV_HI    = 6;
    localparam int SI_OV_LOW   = 7;
    localparam int SI_HOT      = 8;
    localparam int SI_TWO_PH   = 9;
    localparam int SI_EN       = 10;
    localparam int SI_SUPPLY   = 11;
    localparam int NUM_SYNC    = 12;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b] <= 1'b0;
                q_o[b]    <= 1'b0;
            end else begin
                stage1[b] <= d_i[b];
                q_o[b]    <= stage1[b];
            end
        end
    end
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == LAST);
endmodule

// File: rtl/fault_delay.sv
module fault_delay #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // any break in the condition restarts the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (!hold_i)               cnt <= '0;
        else if (tick_i && cnt != TOP)  cnt <= cnt + 1'b1;
    end

    assign expired_o = (cnt == TOP);
endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
    import vr_fault_pkg::*;
#(
    parameter int NPHASE     = 2,
    parameter int TICK_DIV   = 50,
    parameter int OC_TICKS   = 120,
    parameter int LONG_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oc_half_i,
    input  logic              oc_set_i,
    input  logic              oc_short_i,
    input  logic              imbal_i,
    input  logic              uv_i,
    input  logic              ov_lo_i,
    input  logic              ov_hi_i,
    input  logic              ov_low_i,
    input  logic              hot_i,
    input  logic              two_phase_i,
    input  logic              en_i,
    input  logic              supply_ok_i,
    output logic              pgood_o,
    output logic [NPHASE-1:0] hs_en_o,
    output logic [NPHASE-1:0] ls_en_o,
    output logic              ss_req_o,
    output logic              throttle_n_o
);
    logic [NUM_SYNC-1:0] raw, syn;
    logic                tick;
    logic [NUM_DLY-1:0]  hold, expired;
    sup_state_t          state, state_nx;

    assign raw[SI_OC_HALF]  = oc_half_i;
    assign raw[SI_OC_SET]   = oc_set_i;
    assign raw[SI_OC_SHORT] = oc_short_i;
    assign raw[SI_IMBAL]    = imbal_i;
    assign raw[SI_UV]       = uv_i;
    assign raw[SI_OV_LO]    = ov_lo_i;
    assign raw[SI_OV_HI]    = ov_hi_i;
    assign raw[SI_OV_LOW]   = ov_low_i;
    assign raw[SI_HOT]      = hot_i;
    assign raw[SI_TWO_PH]   = two_phase_i;
    assign raw[SI_EN]       = en_i;
    assign raw[SI_SUPPLY]   = supply_ok_i;

    sync_bank #(.WIDTH(NUM_SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    logic two_ph, en_s, sup_s, ov_hi_s, ov_low_s, hot_s;
    logic oc_dly_flag, oc_hard_flag, armed;

    assign two_ph   = syn[SI_TWO_PH];
    assign en_s     = syn[SI_EN];
    assign sup_s    = syn[SI_SUPPLY];
    assign ov_hi_s  = syn[SI_OV_HI];
    assign ov_low_s = syn[SI_OV_LOW];
    assign hot_s    = syn[SI_HOT];

    // single-phase halves the threshold: each tier moves down one flag
    assign oc_dly_flag  = two_ph ? syn[SI_OC_SET]   : syn[SI_OC_HALF];
    assign oc_hard_flag = two_ph ? syn[SI_OC_SHORT] : syn[SI_OC_SET];
    assign armed        = (state == ST_RUN) || (state == ST_START);

    assign hold[DLY_OC]  = armed && oc_dly_flag;
    assign hold[DLY_IMB] = armed && two_ph && syn[SI_IMBAL];
    assign hold[DLY_UV]  = armed && syn[SI_UV];
    assign hold[DLY_OVL] = armed && syn[SI_OV_LO];

    for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
        fault_delay #(.LIMIT((g == DLY_OC) ? OC_TICKS : LONG_TICKS)) u_dly (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick),
            .hold_i    (hold[g]),
            .expired_o (expired[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!sup_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ov_hi_s)   state_nx = ST_CROWBAR;
                    else if (en_s) state_nx = ST_START;
                end
                ST_START, ST_RUN: begin
                    if (ov_hi_s)                         state_nx = ST_CROWBAR;
                    else if (!en_s)                      state_nx = ST_IDLE;
                    else if (oc_hard_flag || |expired)   state_nx = ST_FAULT;
                    else                                 state_nx = ST_RUN;
                end
                ST_FAULT: begin
                    if (ov_hi_s)    state_nx = ST_CROWBAR;
                    else if (!en_s) state_nx = ST_IDLE;
                end
                ST_CROWBAR: begin
                    if (ov_low_s) state_nx = ST_OVLOCK;
                end
                ST_OVLOCK: begin
                    if (ov_hi_s) state_nx = ST_CROWBAR;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pgood_o  = 1'b0;
        hs_en_o  = '0;
        ls_en_o  = '0;
        ss_req_o = 1'b0;
        unique case (state)
            ST_START: begin
                hs_en_o  = '1;
                ls_en_o  = '1;
                ss_req_o = 1'b1;
            end
            ST_RUN: begin
                hs_en_o = '1;
                ls_en_o = '1;
                pgood_o = 1'b1;
            end
            ST_CROWBAR: ls_en_o = '1;
            ST_IDLE, ST_FAULT, ST_OVLOCK: ;
            default: ;
        endcase
    end

    assign throttle_n_o = !hot_s;
endmodule

// File: rtl/vr_fault_checker.sv
module vr_fault_checker #(
    parameter int NPHASE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pgood_o,
    input logic [NPHASE-1:0] hs_en_o,
    input logic [NPHASE-1:0] ls_en_o,
    input logic              ss_req_o,
    input logic              throttle_n_o,
    input logic              hot_i,
    input logic              sup_s,
    input logic              hard_s,
    input logic              armed_s,
    input logic              ov_low_s
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd2) age <= age + 1'b1;
    end

    assert_supply_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!pgood_o && hs_en_o == '0 && ls_en_o == '0));

    assert_hard_oc_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_s && hard_s) |=> (!pgood_o && hs_en_o == '0));

    assert_crowbar_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en_o != '0 && !pgood_o && !ss_req_o && sup_s && !ov_low_s)
        |=> (ls_en_o == '1 && hs_en_o == '0));

    assert_ss_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_o |=> !ss_req_o);

    assert_throttle_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (throttle_n_o == !$past(hot_i, 2)));
endmodule

bind vr_fault_supervisor vr_fault_checker #(.NPHASE(NPHASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pgood_o      (pgood_o),
    .hs_en_o      (hs_en_o),
    .ls_en_o      (ls_en_o),
    .ss_req_o     (ss_req_o),
    .throttle_n_o (throttle_n_o),
    .hot_i        (hot_i),
    .sup_s        (sup_s),
    .hard_s       (oc_hard_flag),
    .armed_s      (armed),
    .ov_low_s     (ov_low_s)
);

// File: tb/vr_fault_supervisor_tb.sv
module vr_fault_supervisor_tb;
    localparam int NPHASE = 2;
    localparam int DIV    = 4;
    localparam int OCT    = 5;
    localparam int LONGT  = 10;

    localparam int RUN_V  = 5'h1F;
    localparam int OFF_V  = 5'h00;
    localparam int CROW_V = 5'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_half, oc_set, oc_short, imbal, uv, ov_lo, ov_hi, ov_low, hot;
    logic two_ph, en, sup;
    logic pgood, ss_req, thr_n;
    logic [NPHASE-1:0] hs, ls;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    vr_fault_supervisor #(
        .NPHASE(NPHASE), .TICK_DIV(DIV), .OC_TICKS(OCT), .LONG_TICKS(LONGT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .oc_half_i(oc_half), .oc_set_i(oc_set), .oc_short_i(oc_short),
        .imbal_i(imbal), .uv_i(uv), .ov_lo_i(ov_lo), .ov_hi_i(ov_hi),
        .ov_low_i(ov_low), .hot_i(hot), .two_phase_i(two_ph),
        .en_i(en), .supply_ok_i(sup),
        .pgood_o(pgood), .hs_en_o(hs), .ls_en_o(ls),
        .ss_req_o(ss_req), .throttle_n_o(thr_n)
    );

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    function automatic int outv();
        return {27'd0, pgood, hs, ls};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet;
        oc_half = 0; oc_set = 0; oc_short = 0; imbal = 0; uv = 0;
        ov_lo = 0; ov_hi = 0; ov_low = 0; hot = 0;
    endtask

    // R2: enable from idle gives one soft-start pulse then run
    task automatic bring_up(input string tag);
        int pulses = 0;
        en = 0; sup = 1;
        wait_cyc(5);
        en = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ss_req) pulses++;
        end
        check({tag, " R2 ss pulses"}, pulses, 1);
        check({tag, " R2 run outputs"}, outv(), RUN_V);
    endtask

    task automatic t_reset;
        wait_cyc(3);
        check("R1 outputs in reset", outv(), OFF_V);
        check("R1 throttle in reset", thr_n, 1);
        rst_n = 1;
        wait_cyc(6);
        check("R1 enable low stays off", outv(), OFF_V);
        check("R1 throttle idle", thr_n, 1);
    endtask

    task automatic t_hard_oc;
        two_ph = 1;
        bring_up("hard2");
        oc_short = 1;
        wait_cyc(4);
        check("R3 two-phase short off", outv(), OFF_V);
        oc_short = 0;
        wait_cyc(10);
        check("R7 fault stays latched", outv(), OFF_V);
        two_ph = 0;
        bring_up("hard1");
        oc_set = 1;
        wait_cyc(4);
        check("R3 single-phase set-level is hard", outv(), OFF_V);
        oc_set = 0;
    endtask

    task automatic t_soft_oc;
        two_ph = 1;
        bring_up("soft");
        oc_set = 1; wait_cyc(12); oc_set = 0;
        wait_cyc(6);
        check("R4 short overload ignored", outv(), RUN_V);
        oc_set = 1; wait_cyc(14); oc_set = 0; wait_cyc(3);
        oc_set = 1; wait_cyc(14); oc_set = 0;
        wait_cyc(6);
        check("R4 broken overload restarts timer", outv(), RUN_V);
        oc_set = 1; wait_cyc(10);
        check("R4 not immediate", outv(), RUN_V);
        wait_cyc(20);
        check("R4 held overload trips", outv(), OFF_V);
        oc_set = 0;
        bring_up("half2");
        oc_half = 1; wait_cyc(50);
        check("R4 half flag ignored two-phase", outv(), RUN_V);
        oc_half = 0;
        two_ph = 0;
        bring_up("half1");
        oc_half = 1; wait_cyc(10);
        check("R4 single-phase half not immediate", outv(), RUN_V);
        wait_cyc(20);
        check("R4 single-phase half trips", outv(), OFF_V);
        oc_half = 0;
    endtask

    task automatic t_imbal;
        two_ph = 0;
        bring_up("imb1");
        imbal = 1; wait_cyc(60);
        check("R5 imbalance masked single-phase", outv(), RUN_V);
        imbal = 0;
        two_ph = 1;
        bring_up("imb2");
        imbal = 1; wait_cyc(30);
        check("R5 imbalance before window", outv(), RUN_V);
        wait_cyc(20);
        check("R5 imbalance trips", outv(), OFF_V);
        imbal = 0;
    endtask

    task automatic t_uv_ov;
        two_ph = 1;
        bring_up("uv");
        uv = 1; wait_cyc(30);
        check("R6 uv before window", outv(), RUN_V);
        wait_cyc(20);
        check("R6 uv trips", outv(), OFF_V);
        uv = 0;
        // R7 supply drop clears and restarts
        sup = 0; wait_cyc(6);
        check("R7 supply drop off", outv(), OFF_V);
        begin
            int pulses = 0;
            sup = 1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (ss_req) pulses++;
            end
            check("R7 restart pulse after supply", pulses, 1);
            check("R7 run after supply", outv(), RUN_V);
        end
        ov_lo = 1; wait_cyc(50);
        check("R6 low overvoltage trips", outv(), OFF_V);
        ov_lo = 0;
    endtask

    task automatic t_ov_hi;
        two_ph = 1;
        bring_up("ovhi");
        ov_hi = 1; wait_cyc(4);
        check("R8 crowbar on", outv(), CROW_V);
        ov_hi = 0; wait_cyc(6);
        check("R8 crowbar holds above release", outv(), CROW_V);
        en = 0; wait_cyc(6);
        check("R10 enable low ignored in crowbar", outv(), CROW_V);
        ov_low = 1; wait_cyc(4);
        check("R8 release turns all off", outv(), OFF_V);
        en = 1; wait_cyc(10);
        check("R10 enable does not clear latch", outv(), OFF_V);
        check("R10 no soft-start while latched", ss_req, 0);
        ov_low = 0; ov_hi = 1; wait_cyc(4);
        check("R9 crowbar repeats", outv(), CROW_V);
        ov_hi = 0; ov_low = 1; wait_cyc(4);
        ov_low = 0;
        sup = 0; wait_cyc(6);
        sup = 1; wait_cyc(8);
        check("R10 supply drop clears latch", outv(), RUN_V);
        uv = 1; wait_cyc(50); uv = 0;
        check("R9 uv fault first", outv(), OFF_V);
        ov_hi = 1; wait_cyc(4);
        check("R9 crowbar after other fault", outv(), CROW_V);
        ov_hi = 0; ov_low = 1; wait_cyc(4); ov_low = 0;
        sup = 0; en = 0; wait_cyc(6); sup = 1; wait_cyc(4);
        ov_hi = 1; wait_cyc(4);
        check("R9 crowbar with enable low", outv(), CROW_V);
        ov_hi = 0; ov_low = 1; wait_cyc(4); ov_low = 0;
        sup = 0; wait_cyc(6); sup = 1;
    endtask

    task automatic t_thermal;
        two_ph = 1;
        bring_up("hot");
        hot = 1; wait_cyc(4);
        check("R11 throttle asserted", thr_n, 0);
        wait_cyc(40);
        check("R11 no effect on regulation", outv(), RUN_V);
        hot = 0; wait_cyc(4);
        check("R11 throttle released", thr_n, 1);
    endtask

    initial begin
        quiet();
        two_ph = 1; en = 0; sup = 1;
        t_reset();
        t_hard_oc();
        t_soft_oc();
        t_imbal();
        t_uv_ov();
        t_ov_hi();
        t_thermal();
        report();
    end
endmodule